// File: doc/BRIEF.md
# I2C 10-bit Slave Address Matcher

This block is the address-phase decision logic of an I2C slave that answers to a 10-bit address. A byte shifter in front of it hands over each completed byte with a one-cycle valid strobe, and a bus monitor hands over single-cycle pulses for Start, Repeated Start and Stop. The matcher checks the high address byte and the low address byte against a programmed 10-bit address. It answers each address byte with an ACK or a NACK pulse and decides whether the slave has been addressed for a write or for a read.

A read in 10-bit mode needs three things in order. First the slave must see a full write-direction match, which sets a prior-match flag. Then the master sends a Repeated Start, and after it the high byte again with the R/W bit set. When a read is granted, the block raises a clock-hold request. The data path keeps SCL low until it is ready and then pulses a release input. Moving data bytes is not part of this block.

All outputs are registered and change on the clock edge that samples the stimulus.

Top module: `addr10_match`

## Requirements
- R1: While reset is active and on the first cycle after it, every output is 0.
- R2: A byte in the high-byte slot matches only when bits 7:3 are 11110 and bits 2:1 equal ownAddr[9:8]. Bit 0 is R/W, where 1 means read. A matching write-direction high byte produces ackValid=1 with ackNack=0 on the next cycle.
- R3: After a matching write-direction high byte, a following byte equal to ownAddr[7:0] is ACKed. On the same next cycle addressed, writeReq and priorMatch are set.
- R4: A mismatching high or low byte gives ackValid=1 with ackNack=1. The block then goes back to waiting for a Start, so the bytes that follow get no ACK/NACK pulse until the next Start.
- R5: priorMatch clears when a high byte arrives with R/W clear, and also when a high byte does not match.
- R6: A Stop clears priorMatch, addressed, writeReq, readReq and holdClk on the next cycle, and the block waits for a Start.
- R7: A Repeated Start clears addressed, writeReq and readReq and keeps priorMatch. The next byte is then taken as a high address byte.
- R8: A matching high byte with R/W set while priorMatch is 1 is ACKed. On the next cycle addressed, readReq and holdClk are set.
- R9: holdClk stays at 1 until holdRelease is pulsed, and it is 0 on the cycle after the pulse.
- R10: A matching high byte with R/W set while priorMatch is 0 is NACKed and does not address the slave.
- R11: Bytes that arrive before any Start, or while the slave is addressed, produce no ACK/NACK pulse and leave every output unchanged.
- R12: writeReq and readReq are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ownAddr | input | 10 | Programmed 10-bit slave address |
| byteValid | input | 1 | One-cycle strobe: byteData holds a completed byte |
| byteData | input | 8 | Received byte |
| startPulse | input | 1 | Start condition seen |
| rstartPulse | input | 1 | Repeated Start condition seen |
| stopPulse | input | 1 | Stop condition seen |
| holdRelease | input | 1 | Data path releases the clock hold |
| addressed | output | 1 | Slave is addressed |
| writeReq | output | 1 | Addressed for a write |
| readReq | output | 1 | Addressed for a read |
| priorMatch | output | 1 | A full write-direction match is on record |
| holdClk | output | 1 | Request to hold SCL low |
| ackValid | output | 1 | One-cycle pulse: answer for the last address byte |
| ackNack | output | 1 | With ackValid: 1 = NACK, 0 = ACK |

## Verification
Every result is due exactly one clock edge after its stimulus. This holds for the ACK/NACK pulse, the addressed and request flags, the prior-match flag and the clock-hold request. The bench drives each stimulus on a falling edge and compares all seven outputs on the next falling edge, after the single rising edge that registers the response. Outputs that should stay as they are, such as the hold request over several idle cycles, are compared again on each following falling edge.

// File: rtl/addr10_pkg.sv
package addr10_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_HI,
    S_WAIT_LO,
    S_ADDR_WR,
    S_ADDR_RD
  } mstate_t;

  typedef struct packed {
    logic clrAll;
    logic clrAddr;
    logic setPrior;
    logic clrPrior;
    logic setWrite;
    logic setRead;
    logic ackStb;
    logic nackStb;
  } strobes_t;
endpackage

// File: rtl/addr10_ctrl.sv
module addr10_ctrl
  import addr10_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     byteValid,
  input  logic     startPulse,
  input  logic     rstartPulse,
  input  logic     stopPulse,
  input  logic     hiMatch,
  input  logic     loMatch,
  input  logic     rwBit,
  input  logic     priorNow,
  output strobes_t str
);
  mstate_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    str = '0;
    if (stopPulse) begin
      str.clrAll = 1'b1;
      stateNxt = S_IDLE;
    end else if (startPulse || rstartPulse) begin
      str.clrAddr = 1'b1;
      stateNxt = S_WAIT_HI;
    end else if (byteValid) begin
      unique case (state)
        S_WAIT_HI: begin
          if (!hiMatch) begin
            str.nackStb = 1'b1;
            str.clrPrior = 1'b1;
            stateNxt = S_IDLE;
          end else if (!rwBit) begin
            str.ackStb = 1'b1;
            str.clrPrior = 1'b1;
            stateNxt = S_WAIT_LO;
          end else if (priorNow) begin
            str.ackStb = 1'b1;
            str.setRead = 1'b1;
            stateNxt = S_ADDR_RD;
          end else begin
            str.nackStb = 1'b1;
            stateNxt = S_IDLE;
          end
        end
        S_WAIT_LO: begin
          if (loMatch) begin
            str.ackStb = 1'b1;
            str.setWrite = 1'b1;
            str.setPrior = 1'b1;
            stateNxt = S_ADDR_WR;
          end else begin
            str.nackStb = 1'b1;
            stateNxt = S_IDLE;
          end
        end
        default: stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  // R4: one answer per byte, never ACK and NACK together
  p_ack_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.ackStb, str.nackStb}));

  // R11: no answer to a byte outside the address phase
  p_no_ans_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE || state == S_ADDR_WR || state == S_ADDR_RD)
      |-> !(str.ackStb || str.nackStb));
endmodule

// File: rtl/addr10_dp.sv
module addr10_dp
  import addr10_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter logic [4:0] HI_TAG = 5'b11110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              holdRelease,
  input  strobes_t          str,
  output logic              hiMatch,
  output logic              loMatch,
  output logic              rwBit,
  output logic              addressed,
  output logic              writeReq,
  output logic              readReq,
  output logic              priorMatch,
  output logic              holdClk,
  output logic              ackValid,
  output logic              ackNack
);
  localparam int HI_BITS = ADDR_W - BYTE_W;

  assign rwBit   = byteData[0];
  assign hiMatch = (byteData[BYTE_W-1 -: 5] == HI_TAG) &&
                   (byteData[HI_BITS:1] == ownAddr[ADDR_W-1 -: HI_BITS]);
  assign loMatch = (byteData == ownAddr[BYTE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addressed  <= 1'b0;
      writeReq   <= 1'b0;
      readReq    <= 1'b0;
      priorMatch <= 1'b0;
      holdClk    <= 1'b0;
      ackValid   <= 1'b0;
      ackNack    <= 1'b0;
    end else begin
      ackValid <= str.ackStb | str.nackStb;
      ackNack  <= str.nackStb;

      if (str.clrAll || str.clrAddr) begin
        addressed <= 1'b0;
        writeReq  <= 1'b0;
        readReq   <= 1'b0;
      end else if (str.setWrite) begin
        addressed <= 1'b1;
        writeReq  <= 1'b1;
      end else if (str.setRead) begin
        addressed <= 1'b1;
        readReq   <= 1'b1;
      end

      if (str.clrAll || str.clrPrior) priorMatch <= 1'b0;
      else if (str.setPrior)          priorMatch <= 1'b1;

      if (str.setRead)                       holdClk <= 1'b1;
      else if (str.clrAll || holdRelease)    holdClk <= 1'b0;
    end
  end

  p_req_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(writeReq && readReq));

  p_req_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (writeReq || readReq) |-> addressed);

  p_stop_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    str.clrAll |=> !(priorMatch || addressed || holdClk));

  p_hold_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (holdRelease && !str.setRead) |=> !holdClk);

  p_read_prior_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readReq) |-> $past(priorMatch));
endmodule

// File: rtl/addr10_match.sv
module addr10_match
  import addr10_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              startPulse,
  input  logic              rstartPulse,
  input  logic              stopPulse,
  input  logic              holdRelease,
  output logic              addressed,
  output logic              writeReq,
  output logic              readReq,
  output logic              priorMatch,
  output logic              holdClk,
  output logic              ackValid,
  output logic              ackNack
);
  strobes_t str;
  logic hiMatch, loMatch, rwBit;

  addr10_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid),
    .startPulse(startPulse), .rstartPulse(rstartPulse), .stopPulse(stopPulse),
    .hiMatch(hiMatch), .loMatch(loMatch), .rwBit(rwBit),
    .priorNow(priorMatch), .str(str)
  );

  addr10_dp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .ownAddr(ownAddr), .byteData(byteData),
    .holdRelease(holdRelease), .str(str),
    .hiMatch(hiMatch), .loMatch(loMatch), .rwBit(rwBit),
    .addressed(addressed), .writeReq(writeReq), .readReq(readReq),
    .priorMatch(priorMatch), .holdClk(holdClk),
    .ackValid(ackValid), .ackNack(ackNack)
  );
endmodule

// File: tb/test_addr10_match.sv
module test_addr10_match;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] ownAddr = 10'h2A5;
  logic byteValid = 1'b0, startPulse = 1'b0, rstartPulse = 1'b0;
  logic stopPulse = 1'b0, holdRelease = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic addressed, writeReq, readReq, priorMatch, holdClk, ackValid, ackNack;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  addr10_match i_addr10_match (.*);

  // kind: 0 idle, 1 start, 2 rstart, 3 stop, 4 byte, 5 release
  // expected: {ackValid, ackNack, addressed, writeReq, readReq, priorMatch, holdClk}
  localparam int NV = 28;
  localparam logic [22:0] VEC [NV] = '{
    {4'd11, 4'd4, 8'hF4, 7'b0000000}, // R11 byte before any Start
    {4'd1,  4'd1, 8'h00, 7'b0000000},
    {4'd2,  4'd4, 8'hF4, 7'b1000000}, // R2 high write byte ACK
    {4'd3,  4'd4, 8'hA5, 7'b1011010}, // R3 full match
    {4'd11, 4'd4, 8'h55, 7'b0011010}, // R11 data byte ignored
    {4'd7,  4'd2, 8'h00, 7'b0000010}, // R7 rstart keeps prior
    {4'd8,  4'd4, 8'hF5, 7'b1010111}, // R8 read granted
    {4'd9,  4'd0, 8'h00, 7'b0010111}, // R9 hold kept
    {4'd9,  4'd5, 8'h00, 7'b0010110}, // R9 released
    {4'd6,  4'd3, 8'h00, 7'b0000000}, // R6 stop
    {4'd1,  4'd1, 8'h00, 7'b0000000},
    {4'd10, 4'd4, 8'hF5, 7'b1100000}, // R10 read without prior
    {4'd4,  4'd4, 8'hF4, 7'b0000000}, // R4 idle after NACK
    {4'd1,  4'd1, 8'h00, 7'b0000000},
    {4'd2,  4'd4, 8'hF4, 7'b1000000},
    {4'd4,  4'd4, 8'hA4, 7'b1100000}, // R4 low mismatch
    {4'd1,  4'd1, 8'h00, 7'b0000000},
    {4'd2,  4'd4, 8'hF4, 7'b1000000},
    {4'd3,  4'd4, 8'hA5, 7'b1011010},
    {4'd7,  4'd2, 8'h00, 7'b0000010},
    {4'd5,  4'd4, 8'hF2, 7'b1100000}, // R5 high mismatch clears prior
    {4'd1,  4'd1, 8'h00, 7'b0000000},
    {4'd2,  4'd4, 8'hF4, 7'b1000000},
    {4'd3,  4'd4, 8'hA5, 7'b1011010},
    {4'd7,  4'd2, 8'h00, 7'b0000010},
    {4'd5,  4'd4, 8'hF4, 7'b1000000}, // R5 high write clears prior
    {4'd3,  4'd4, 8'hA5, 7'b1011010},
    {4'd6,  4'd3, 8'h00, 7'b0000000}
  };

  task automatic step(input logic [3:0] kind, input logic [7:0] d);
    byteData    = d;
    byteValid   = (kind == 4'd4);
    startPulse  = (kind == 4'd1);
    rstartPulse = (kind == 4'd2);
    stopPulse   = (kind == 4'd3);
    holdRelease = (kind == 4'd5);
    @(negedge clk);
    {byteValid, startPulse, rstartPulse, stopPulse, holdRelease} = '0;
  endtask

  task automatic check(input int req, input logic [6:0] exp);
    logic [6:0] act;
    act = {ackValid, ackNack, addressed, writeReq, readReq, priorMatch, holdClk};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d: outputs %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 7'b0); // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    check(1, 7'b0); // R1 after reset

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18:15], VEC[i][14:7]);
      check(int'(VEC[i][22:19]), VEC[i][6:0]);
    end

    // R2 R3 with another address: high byte 11110_01_x, low 7F
    ownAddr = 10'h17F;
    step(4'd1, 8'h00); check(2, 7'b0000000);
    step(4'd4, 8'hF4); check(2, 7'b1100000); // old high bits now mismatch
    step(4'd1, 8'h00);
    step(4'd4, 8'hF2); check(2, 7'b1000000);
    step(4'd4, 8'h7F); check(3, 7'b1011010);
    step(4'd2, 8'h00); check(7, 7'b0000010);
    step(4'd4, 8'hF3); check(8, 7'b1010111);
    for (int k = 0; k < 4; k++) begin
      step(4'd0, 8'h00); check(9, 7'b0010111);
    end
    step(4'd4, 8'h12); check(11, 7'b0010111); // byte while read-addressed
    step(4'd3, 8'h00); check(6, 7'b0000000);  // stop clears hold

    // R12 exclusivity seen at ports across a write then read
    step(4'd1, 8'h00);
    step(4'd4, 8'hF2);
    step(4'd4, 8'h7F);
    check(12, 7'b1011010);
    step(4'd2, 8'h00);
    step(4'd4, 8'hF3);
    check(12, 7'b1010111);

    // R1 reset mid-transaction
    rstN = 1'b0;
    @(negedge clk);
    check(1, 7'b0000000);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 7'b0000000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule